// File: doc/BRIEF.md
# 16-bit PWM Timer with Overlaid Registers

This block is a 16-bit timer peripheral behind a byte-wide register port. A prescaler turns the system clock into a single-cycle count enable. That enable advances one 16-bit counter, which serves three uses. In PWM mode the counter sweeps a programmable period and drives a pulse output whose active time is set by a duty register. With PWM off, the counter either clears on a match against a timer data register and emits a one-cycle match pulse, or it runs freely and is latched into a capture register on a rising edge of a synchronized input.

Several logical registers share the same byte addresses. The mode bits decide what a read returns and which register a write changes. The period and duty values can be changed only while PWM is enabled. A write to those addresses with PWM disabled goes to the timer data register instead. Software enables PWM first and then loads the period and duty bytes, low byte then high byte.

Top module: `pwm_timer16`

## Requirements
- R1: The clock-select field in bits [2:0] of the clock register (address 0) sets the count-enable ratio to 2^(sel+1) system clocks, so sel=0 divides by 2 and sel=7 divides by 256.
- R2: In PWM mode (bit 0 of the mode register at address 1 set), the counter runs from 0 up to the 16-bit period value P and then wraps to 0, so one PWM period lasts (P+1) count enables.
- R3: In PWM mode the output is active while the counter is at or below the duty value D, which gives (D+1) active enables from each wrap. Mode bit 2 selects the active level: 1 means active high and 0 means active low. With PWM disabled, the output holds the inactive level.
- R4: When D is greater than or equal to P, the output stays at its active level for the whole period.
- R5: Writes to the period bytes (address 4 low, 5 high) and the duty bytes (address 2 low, 3 high) take effect only while PWM is enabled. With PWM disabled, these writes update the timer data register and leave period and duty unchanged.
- R6: A read at address 2 returns the low byte and a read at address 3 returns the high byte. The byte comes from the duty register when PWM is enabled, from the capture register in capture mode (mode bit 1 set), and from the live counter in compare mode. Reads at addresses 4 to 7 return 0x00, and addresses 0 and 1 read back their fields.
- R7: After reset, the clock and mode registers, the duty register and the counter are 0, and the period and timer data registers are 0xFFFF.
- R8: In compare mode, the counter clears on the count enable at which it equals the timer data value T. A one-cycle match pulse follows, so pulses repeat every (T+1) enables.
- R9: In capture mode, a rising edge of the capture input is passed through a SYNC_STAGES-flop synchronizer and then latches the counter value. Between edges the capture register holds its value.
- R10: Any write to the mode register clears the counter and the prescaler, so counting restarts from 0 with a full prescale interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| cap_in | input | 1 | Asynchronous capture trigger |
| pwm_out | output | 1 | PWM output |
| match_pulse | output | 1 | One-cycle compare-match pulse |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. This makes the capture latency a fixed, known number of edges, so the bench can predict the captured counter value exactly from the cycle at which the mode write restarted counting. Clock selects 0, 1, 2 and 7 exercise both the fastest ratio and the 256-clock ratio. A period above 0xFF checks that the high byte takes part in the compare.

// File: rtl/pwm_timer16.sv
module pwm_timer16 #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cap_in,
  output logic       pwm_out,
  output logic       match_pulse
);

  localparam int CW = 16;
  localparam int PW = 8;

  logic [2:0]    clk_sel;
  logic          pwm_en, cap_mode, pol;
  logic [CW-1:0] period_q, duty_q, cmp_q, cnt_q, cap_q;
  logic [PW-1:0] psc_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic          prev_q;

  wire [PW-1:0] psc_mask = PW'((9'd2 << clk_sel) - 9'd1);
  wire tick     = (psc_q & psc_mask) == psc_mask;
  wire mode_wr  = reg_wr && reg_addr == 3'd1;
  wire cap_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  wire active   = cnt_q <= duty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sel  <= '0;
      pwm_en   <= 1'b0;
      cap_mode <= 1'b0;
      pol      <= 1'b0;
      period_q <= '1;
      duty_q   <= '0;
      cmp_q    <= '1;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: clk_sel <= reg_wdata[2:0];
        3'd1: {pol, cap_mode, pwm_en} <= reg_wdata[2:0];
        3'd2: if (pwm_en) duty_q[7:0]    <= reg_wdata; else cmp_q[7:0]  <= reg_wdata;
        3'd3: if (pwm_en) duty_q[15:8]   <= reg_wdata; else cmp_q[15:8] <= reg_wdata;
        3'd4: if (pwm_en) period_q[7:0]  <= reg_wdata; else cmp_q[7:0]  <= reg_wdata;
        3'd5: if (pwm_en) period_q[15:8] <= reg_wdata; else cmp_q[15:8] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_q       <= '0;
      cnt_q       <= '0;
      match_pulse <= 1'b0;
    end else if (mode_wr) begin
      psc_q       <= '0;
      cnt_q       <= '0;
      match_pulse <= 1'b0;
    end else begin
      psc_q       <= psc_q + PW'(1);
      match_pulse <= tick && !pwm_en && !cap_mode && cnt_q == cmp_q;
      if (tick) begin
        if (pwm_en)
          cnt_q <= (cnt_q >= period_q) ? '0 : cnt_q + CW'(1);
        else if (!cap_mode)
          cnt_q <= (cnt_q == cmp_q) ? '0 : cnt_q + CW'(1);
        else
          cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cap_in};
      prev_q <= sync_q[SYNC_STAGES-1];
      if (cap_rise && cap_mode) cap_q <= cnt_q;
    end
  end

  wire [CW-1:0] data_view = pwm_en ? duty_q : (cap_mode ? cap_q : cnt_q);

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {5'd0, clk_sel};
      3'd1:    reg_rdata = {5'd0, pol, cap_mode, pwm_en};
      3'd2:    reg_rdata = data_view[7:0];
      3'd3:    reg_rdata = data_view[15:8];
      default: reg_rdata = 8'h00;
    endcase
  end

  assign pwm_out = pwm_en ? (pol ? active : ~active) : ~pol;

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && tick && cnt_q >= period_q) |=> cnt_q == '0);

  assert_start_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && cnt_q == '0) |-> pwm_out == pol);

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |-> pwm_out == !pol);

  assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && duty_q >= period_q && cnt_q <= period_q) |-> pwm_out == pol);

  assert_duty_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> $stable(duty_q) && $stable(period_q));

  assert_match_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> cnt_q == '0);

  assert_capture_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_rise |=> $stable(cap_q));

  assert_mode_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> cnt_q == '0 && psc_q == '0);

endmodule

// File: tb/sim_pwm_timer16.sv
module sim_pwm_timer16;
  localparam int SYNC = 2;

  typedef struct packed {
    logic [2:0]  sel;
    logic [15:0] per;
    logic [15:0] duty;
    logic        pol;
    logic [15:0] exp_act;
    logic [15:0] exp_inact;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{3'd0, 16'd9,     16'd3,     1'b1, 16'd8,   16'd12},
    '{3'd2, 16'd4,     16'd0,     1'b0, 16'd8,   16'd32},
    '{3'd1, 16'd15,    16'd14,    1'b1, 16'd60,  16'd4},
    '{3'd0, 16'h0103,  16'h0080,  1'b1, 16'd258, 16'd262},
    '{3'd7, 16'd1,     16'd0,     1'b1, 16'd256, 16'd256}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic cap_in = 1'b0;
  logic pwm_out, match_pulse;

  int checks = 0, errors = 0;
  logic [7:0] rd;
  int a, n, bad;

  always #5 clk = ~clk;

  pwm_timer16 #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
    .pwm_out(pwm_out), .match_pulse(match_pulse));

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] addr, input logic [7:0] data);
    @(negedge clk);
    reg_addr = addr; reg_wdata = data; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdb(input logic [2:0] addr, output logic [7:0] v);
    reg_addr = addr;
    #1 v = reg_rdata;
  endtask

  task automatic measure(input logic act, output int na, output int ni);
    @(negedge clk);
    while (pwm_out === act) @(negedge clk);
    while (pwm_out !== act) @(negedge clk);
    na = 0;
    while (pwm_out === act) begin na++; @(negedge clk); end
    ni = 0;
    while (pwm_out !== act) begin ni++; @(negedge clk); end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: reset values
    rdb(3'd0, rd); check("R7 clock reg", rd, 0);
    rdb(3'd1, rd); check("R7 mode reg", rd, 0);
    rdb(3'd3, rd); check("R7 counter high", rd, 0);
    rdb(3'd4, rd); check("R6 write-only reads zero", rd, 0);
    wr(3'd1, 8'h01);
    rdb(3'd2, rd); check("R7 duty low", rd, 0);
    rdb(3'd3, rd); check("R7 duty high", rd, 0);

    // R1 R2 R3: table walk
    for (int i = 0; i < 5; i++) begin
      wr(3'd0, {5'd0, VEC[i].sel});
      wr(3'd1, {5'd0, VEC[i].pol, 2'b01});
      wr(3'd4, VEC[i].per[7:0]);
      wr(3'd5, VEC[i].per[15:8]);
      wr(3'd2, VEC[i].duty[7:0]);
      wr(3'd3, VEC[i].duty[15:8]);
      wr(3'd1, {5'd0, VEC[i].pol, 2'b01});
      rdb(3'd2, rd); check("R6 duty low readback", rd, VEC[i].duty[7:0]);
      rdb(3'd3, rd); check("R6 duty high readback", rd, VEC[i].duty[15:8]);
      measure(VEC[i].pol, a, n);
      check("R3 R1 active length", a, VEC[i].exp_act);
      check("R2 R1 inactive length", n, VEC[i].exp_inact);
    end

    // R4: duty equal to and above period
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h05);
    wr(3'd4, 8'd3); wr(3'd5, 8'd0);
    wr(3'd2, 8'd3); wr(3'd3, 8'd0);
    wr(3'd1, 8'h05);
    bad = 0;
    for (int c = 0; c < 100; c++) begin @(negedge clk); if (pwm_out !== 1'b1) bad++; end
    check("R4 duty==period always active", bad, 0);
    wr(3'd2, 8'h00); wr(3'd3, 8'h02);
    bad = 0;
    for (int c = 0; c < 100; c++) begin @(negedge clk); if (pwm_out !== 1'b1) bad++; end
    check("R4 duty>period always active", bad, 0);

    // R3 idle level, R5 redirected writes, R8 compare
    wr(3'd1, 8'h04);
    @(negedge clk);
    check("R3 idle level with pwm off", pwm_out, 0);
    wr(3'd2, 8'h77); wr(3'd3, 8'h00);
    wr(3'd4, 8'd5);  wr(3'd5, 8'd0);
    wr(3'd1, 8'h04);
    repeat (6) @(negedge clk);
    rdb(3'd2, rd); check("R6 R10 live counter low", rd, 3);
    rdb(3'd3, rd); check("R6 live counter high", rd, 0);
    while (match_pulse !== 1'b1) @(negedge clk);
    a = 0;
    do begin @(negedge clk); a++; end while (match_pulse !== 1'b1);
    check("R8 match spacing", a, 12);

    wr(3'd1, 8'h05);
    rdb(3'd2, rd); check("R5 duty low kept", rd, 8'h00);
    rdb(3'd3, rd); check("R5 duty high kept", rd, 8'h02);
    wr(3'd2, 8'd1); wr(3'd3, 8'd0);
    wr(3'd1, 8'h05);
    measure(1'b1, a, n);
    check("R5 period kept active", a, 4);
    check("R5 period kept inactive", n, 4);

    // R9 R10: capture
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h02);
    repeat (40) @(negedge clk);
    cap_in = 1'b1;
    repeat (10) @(negedge clk);
    rdb(3'd2, rd); check("R9 R10 capture low", rd, (40 + SYNC) / 2);
    rdb(3'd3, rd); check("R9 capture high", rd, 0);
    check("R3 idle level active-low", pwm_out, 1);
    repeat (30) @(negedge clk);
    rdb(3'd2, rd); check("R9 capture held", rd, (40 + SYNC) / 2);
    cap_in = 1'b0;
    repeat (5) @(negedge clk);
    cap_in = 1'b1;
    repeat (10) @(negedge clk);
    rdb(3'd2, rd); check("R9 second capture", rd, (85 + SYNC) / 2);

    report();
  end
endmodule